// File: doc/BRIEF.md
# Four-Queue Read Port with Registered Output-Valid Flag

This block is the read side of a four-queue first-word-fall-through buffer. Every queue keeps its own occupancy, which changes on writes whether or not that queue is selected for reading. One queue at a time is active on the read port. Its head word sits in a read output register, and a one-bit flag, `out_invalid`, tells whether that word is real. The flag is high when the word is not valid. It changes only on the rising clock edge that loads the register, so the flag always describes the word the register holds, not the raw occupancy of the queue.

A read-queue change is requested with `rd_sel` and an address. The low address bits pick the queue and the top bits carry a device ID. The request is latched on one edge and takes effect on the next, so the new queue's head word and flag appear two clocks after the request is presented. Up to that point the old queue keeps running: reads continue to advance it, and the flag keeps reporting on its words. The word shown when a queue is left is not consumed, so it is shown again when that queue is reselected.

Several devices can share one flag wire. The flag pin is driven only when the ID bits of the last committed selection equal the strapped `id_strap` value. Otherwise the pin floats and this device ignores reads.

The read sequencer has four named states:
- `ST_SHOW_EMPTY`: the register holds no valid word.
- `ST_SHOW_WORD`: the register holds a valid word.
- `ST_SW_EMPTY`: a switch is pending and the current word is not valid.
- `ST_SW_WORD`: a switch is pending and the current word is valid.

Its transitions are:
- **fall-through**: `ST_SHOW_EMPTY` to `ST_SHOW_WORD`, when the active queue holds data.
- **advance**: `ST_SHOW_WORD` stays in `ST_SHOW_WORD` on a read while more words remain.
- **drain**: `ST_SHOW_WORD` to `ST_SHOW_EMPTY` on a read of the last word.
- **request**: any `ST_SHOW_*` state to the matching `ST_SW_*` state, when `rd_sel` is high.
- **commit**: an `ST_SW_*` state to `ST_SHOW_WORD` or `ST_SHOW_EMPTY`, depending on the new queue.
- **re-request**: an `ST_SW_*` state to an `ST_SW_*` state, when `rd_sel` is high on the commit edge.

Top module: `mq_ov_read`

## Requirements
- R1: After reset, `out_invalid` is 1, `out_invalid_oe` is 0 and every queue is empty.
- R2: A write to a queue, selected for reading or not, adds to that queue's stored words. A later selection of that queue shows them in write order.
- R3: When the output is invalid and the active queue receives a word on edge e, the word appears on `rd_data` with `out_invalid` 0 after edge e+1.
- R4: On an edge with `rd_en_n` = 0, a valid output and more than one stored word, `rd_data` takes the next word of the same queue and `out_invalid` stays 0.
- R5: On an edge with `rd_en_n` = 0 while the last stored word is shown, `out_invalid` becomes 1.
- R6: A read while `out_invalid` is 1 changes neither `rd_data` nor the flag, and discards no data.
- R7: `rd_addr` is latched on an edge with `rd_sel` = 1. Bits [1:0] of `rd_addr` give the queue and bits [4:2] give the device ID. On the next edge, `rd_data` and `out_invalid` switch to the new queue. On the latch edge itself, the old queue still serves reads.
- R8: Leaving a queue does not consume its shown word. Reselecting the queue shows that word again.
- R9: `out_invalid_oe` is 1 exactly when the ID bits of the last committed selection equal `id_strap`, and it changes only on commit edges. While `out_invalid_oe` is 1, `out_invalid_bus` equals `out_invalid`; otherwise it is high-impedance.
- R10: With no read, no commit and no word arriving for an empty active queue, `rd_data` and `out_invalid` hold. This includes writes to other queues.
- R11: Reads are ignored while `out_invalid_oe` is 0.
- R12: A `rd_sel` on a commit edge commits the pending queue and starts a new switch, which commits on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read/write clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_q | input | 2 | Queue written |
| wr_data | input | 8 | Word written |
| rd_en_n | input | 1 | Read enable, active low |
| rd_sel | input | 1 | Read-queue change request |
| rd_addr | input | 5 | {device ID[2:0], queue[1:0]} |
| id_strap | input | 3 | Static device ID |
| rd_data | output | 8 | Read output register |
| out_invalid | output | 1 | 1 = `rd_data` not valid |
| out_invalid_oe | output | 1 | Flag pin drive enable |
| out_invalid_bus | output | 1 | Shared flag pin, high-impedance when not driven |

## Verification
The hardest cases are edges where two things happen at once. One is a switch request arriving together with a read of the old queue. Another is a second request landing exactly on the commit edge of the first. A third is a shown word that has to survive being left, and reads that arrive while the device is deselected. The stimulus drives `rd_sel` and `rd_en_n` in the same cycle and issues back-to-back requests. It also leaves and revisits a queue with a word still displayed, and switches to a foreign ID and back. A sweep over every queue with one to three stored words checks fall-through, advance and drain using values computed from queue and position.

// File: rtl/mq_ov_pkg.sv
package mq_ov_pkg;
    typedef enum logic [1:0] {
        ST_SHOW_EMPTY = 2'd0,
        ST_SHOW_WORD  = 2'd1,
        ST_SW_EMPTY   = 2'd2,
        ST_SW_WORD    = 2'd3
    } rd_state_e;
endpackage

// File: rtl/mq_queue_bank.sv
module mq_queue_bank #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [DW-1:0] nxt,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rptr, wptr;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_pop  = pop && (count != '0);
    assign do_push = push && ((count < CW'(DEPTH)) || do_pop);
    assign head    = mem[rptr];
    assign nxt     = mem[bump(rptr)];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds the storage
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R6: the sequencer never pops a queue that holds nothing
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/mq_flag_port.sv
module mq_flag_port #(
    parameter int QW   = 2,
    parameter int ID_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W+QW-1:0] rd_addr,
    input  logic [ID_W-1:0]    id_strap,
    output logic [QW-1:0]      sel_q,
    output logic               sel_match,
    input  logic               out_invalid,
    input  logic               drive_en,
    output logic               flag_bus
);
    assign sel_q     = rd_addr[QW-1:0];
    assign sel_match = (rd_addr[ID_W+QW-1:QW] == id_strap);
    assign flag_bus  = drive_en ? out_invalid : 1'bz;

    // R9: when this device owns the pin it shows the flag
    p_bus_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> flag_bus == out_invalid);
endmodule

// File: rtl/mq_rd_sequencer.sv
module mq_rd_sequencer
    import mq_ov_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int QW   = $clog2(NQ),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en_n,
    input  logic                   rd_sel,
    input  logic [QW-1:0]          sel_q,
    input  logic                   sel_match,
    input  logic [NQ-1:0][CW-1:0]  q_cnt,
    input  logic [NQ-1:0][DW-1:0]  q_head,
    input  logic [NQ-1:0][DW-1:0]  q_next,
    output logic [NQ-1:0]          q_pop,
    output logic [DW-1:0]          out_word,
    output logic                   out_invalid,
    output logic                   drive_en
);
    rd_state_e     state, state_n;
    logic [QW-1:0] act_q, act_n, pend_q;
    logic          pend_match, dev_sel, dev_n;
    logic [DW-1:0] word_n;
    logic [CW-1:0] act_cnt, pend_cnt;
    logic [DW-1:0] act_head, act_nxt, pend_head, pend_nxt;
    logic          rd_go, showing, committing, pop_act, same_q, load_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SHOW_EMPTY;
        else        state <= state_n;
    end

    // next-state and next-word decode
    always_comb begin
        act_cnt    = q_cnt[act_q];
        act_head   = q_head[act_q];
        act_nxt    = q_next[act_q];
        pend_cnt   = q_cnt[pend_q];
        pend_head  = q_head[pend_q];
        pend_nxt   = q_next[pend_q];
        rd_go      = !rd_en_n && dev_sel;
        showing    = (state == ST_SHOW_WORD) || (state == ST_SW_WORD);
        committing = (state == ST_SW_EMPTY) || (state == ST_SW_WORD);
        pop_act    = showing && rd_go;
        same_q     = (pend_q == act_q);
        load_valid = 1'b0;
        word_n     = out_word;
        act_n      = act_q;
        dev_n      = dev_sel;
        unique case (state)
            ST_SHOW_EMPTY: begin
                // fall-through
                if (act_cnt != '0) begin
                    load_valid = 1'b1;
                    word_n     = act_head;
                end
            end
            ST_SHOW_WORD: begin
                load_valid = 1'b1;
                if (rd_go) begin
                    // advance or drain
                    if (act_cnt > CW'(1)) word_n = act_nxt;
                    else                  load_valid = 1'b0;
                end
            end
            ST_SW_EMPTY, ST_SW_WORD: begin
                // commit
                act_n = pend_q;
                dev_n = pend_match;
                if (pop_act && same_q) begin
                    if (pend_cnt > CW'(1)) begin
                        load_valid = 1'b1;
                        word_n     = pend_nxt;
                    end
                end else if (pend_cnt != '0) begin
                    load_valid = 1'b1;
                    word_n     = pend_head;
                end
            end
            default: ;
        endcase
        if (rd_sel) state_n = load_valid ? ST_SW_WORD   : ST_SW_EMPTY;
        else        state_n = load_valid ? ST_SHOW_WORD : ST_SHOW_EMPTY;
        q_pop        = '0;
        q_pop[act_q] = pop_act;
    end

    // registered outputs and selection pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word   <= '0;
            act_q      <= '0;
            pend_q     <= '0;
            pend_match <= 1'b0;
            dev_sel    <= 1'b0;
        end else begin
            out_word <= word_n;
            act_q    <= act_n;
            dev_sel  <= dev_n;
            if (rd_sel) begin
                pend_q     <= sel_q;
                pend_match <= sel_match;
            end
        end
    end

    assign out_invalid = !((state == ST_SHOW_WORD) || (state == ST_SW_WORD));
    assign drive_en    = dev_sel;

    // R4: a read with words remaining shows the next word
    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (showing && !committing && rd_go && act_cnt > CW'(1))
        |=> (!out_invalid && out_word == $past(act_nxt)));
    // R5: reading the last word invalidates the output
    p_last_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (showing && !committing && rd_go && act_cnt == CW'(1)) |=> out_invalid);
    // R6: an empty active queue keeps the register and flag
    p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!showing && !committing && act_cnt == '0)
        |=> (out_invalid && $stable(out_word)));
    // R7: a request is always followed by a commit edge
    p_commit_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |=> committing);
    // R9: the drive enable moves only on commits
    p_oe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !committing |=> $stable(drive_en));
    // R10: no read and no commit keeps a valid word
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (showing && !committing && !rd_go) |=> (!out_invalid && $stable(out_word)));
endmodule

// File: rtl/mq_ov_read.sv
module mq_ov_read #(
    parameter int NQ    = 4,
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int ID_W  = 3,
    localparam int QW   = $clog2(NQ),
    localparam int AW   = ID_W + QW,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [QW-1:0]   wr_q,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_en_n,
    input  logic            rd_sel,
    input  logic [AW-1:0]   rd_addr,
    input  logic [ID_W-1:0] id_strap,
    output logic [DW-1:0]   rd_data,
    output logic            out_invalid,
    output logic            out_invalid_oe,
    output logic            out_invalid_bus
);
    logic [NQ-1:0][CW-1:0] q_cnt;
    logic [NQ-1:0][DW-1:0] q_head, q_next;
    logic [NQ-1:0]         q_pop;
    logic [QW-1:0]         sel_q;
    logic                  sel_match;

    for (genvar g = 0; g < NQ; g++) begin : g_bank
        mq_queue_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (wr_en && (wr_q == QW'(g))),
            .pop   (q_pop[g]),
            .wdata (wr_data),
            .head  (q_head[g]),
            .nxt   (q_next[g]),
            .count (q_cnt[g])
        );
    end

    mq_rd_sequencer #(.NQ(NQ), .DW(DW), .DEPTH(DEPTH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en_n     (rd_en_n),
        .rd_sel      (rd_sel),
        .sel_q       (sel_q),
        .sel_match   (sel_match),
        .q_cnt       (q_cnt),
        .q_head      (q_head),
        .q_next      (q_next),
        .q_pop       (q_pop),
        .out_word    (rd_data),
        .out_invalid (out_invalid),
        .drive_en    (out_invalid_oe)
    );

    mq_flag_port #(.QW(QW), .ID_W(ID_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_addr     (rd_addr),
        .id_strap    (id_strap),
        .sel_q       (sel_q),
        .sel_match   (sel_match),
        .out_invalid (out_invalid),
        .drive_en    (out_invalid_oe),
        .flag_bus    (out_invalid_bus)
    );
endmodule

// File: tb/tb_mq_ov_read.sv
`timescale 1ns/1ps
module tb_mq_ov_read;
    localparam int MYID = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_q = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en_n = 1'b1;
    logic       rd_sel = 1'b0;
    logic [4:0] rd_addr = '0;
    logic [2:0] id_strap = 3'(MYID);
    logic [7:0] rd_data;
    logic       out_invalid, out_invalid_oe, out_invalid_bus;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    mq_ov_read dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
        .rd_en_n(rd_en_n), .rd_sel(rd_sel), .rd_addr(rd_addr), .id_strap(id_strap),
        .rd_data(rd_data), .out_invalid(out_invalid), .out_invalid_oe(out_invalid_oe),
        .out_invalid_bus(out_invalid_bus)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int q, input int d);
        wr_en = 1'b1; wr_q = 2'(q); wr_data = 8'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic sel(input int id, input int q);
        rd_sel = 1'b1; rd_addr = {3'(id), 2'(q)};
        step();
        rd_sel = 1'b0;
    endtask

    task automatic rd();
        rd_en_n = 1'b0;
        step();
        rd_en_n = 1'b1;
    endtask

    function automatic int wval(input int q, input int n, input int i);
        return q * 64 + n * 16 + i;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) step();
        chk("R1 flag after reset", 32'(out_invalid), 1);
        chk("R1 oe after reset", 32'(out_invalid_oe), 0);
        rst_n = 1'b1;
        step();

        sel(MYID, 0);
        chk("R7 oe before commit", 32'(out_invalid_oe), 0);
        step();
        chk("R9 oe on match", 32'(out_invalid_oe), 1);
        chk("R1 empty queue flag", 32'(out_invalid), 1);
        chk("R9 bus follows flag", 32'(out_invalid_bus), 32'(out_invalid));

        wr(1, 8'h10); wr(1, 8'h11); wr(1, 8'h12);
        step();
        chk("R10 other-queue write keeps flag", 32'(out_invalid), 1);
        rd();
        chk("R6 read on empty keeps flag", 32'(out_invalid), 1);

        wr(0, 8'h01);
        chk("R3 not yet visible", 32'(out_invalid), 1);
        step();
        chk("R3 fall-through flag", 32'(out_invalid), 0);
        chk("R3 fall-through data", 32'(rd_data), 32'h01);

        sel(MYID, 1);
        chk("R7 old data during switch", 32'(rd_data), 32'h01);
        chk("R7 old flag during switch", 32'(out_invalid), 0);
        step();
        chk("R2 unselected writes visible", 32'(rd_data), 32'h10);
        chk("R7 new flag", 32'(out_invalid), 0);
        rd();
        chk("R4 advance 1", 32'(rd_data), 32'h11);
        rd();
        chk("R4 advance 2", 32'(rd_data), 32'h12);
        rd();
        chk("R5 last word read", 32'(out_invalid), 1);
        rd();
        chk("R6 flag held", 32'(out_invalid), 1);
        chk("R6 data held", 32'(rd_data), 32'h12);

        sel(MYID, 0);
        step();
        chk("R8 kept word", 32'(rd_data), 32'h01);
        chk("R8 kept flag", 32'(out_invalid), 0);
        rd();
        chk("R5 drain q0", 32'(out_invalid), 1);

        for (int q = 0; q < 4; q++) begin
            for (int n = 1; n <= 3; n++) begin
                sel(MYID, q);
                step();
                chk("R7 sweep empty queue", 32'(out_invalid), 1);
                for (int i = 0; i < n; i++) wr(q, wval(q, n, i));
                step();
                chk("R3 sweep first word", 32'(rd_data), 32'(wval(q, n, 0)));
                chk("R3 sweep flag", 32'(out_invalid), 0);
                for (int i = 0; i < n; i++) begin
                    rd();
                    if (i < n - 1) chk("R4 sweep advance", 32'(rd_data), 32'(wval(q, n, i + 1)));
                    else           chk("R5 sweep drain", 32'(out_invalid), 1);
                end
            end
        end

        wr(2, 8'hA0); wr(2, 8'hA1); wr(3, 8'hB0);
        sel(MYID, 2);
        step();
        chk("R7 shows q2", 32'(rd_data), 32'hA0);
        rd_sel = 1'b1; rd_addr = {3'(MYID), 2'd3}; rd_en_n = 1'b0;
        step();
        rd_sel = 1'b0; rd_en_n = 1'b1;
        chk("R7 old queue read on latch edge", 32'(rd_data), 32'hA1);
        chk("R7 old flag on latch edge", 32'(out_invalid), 0);
        step();
        chk("R7 new queue on commit", 32'(rd_data), 32'hB0);
        sel(MYID, 2);
        step();
        chk("R8 word retained after leave", 32'(rd_data), 32'hA1);

        sel(MYID, 3);
        rd_sel = 1'b1; rd_addr = {3'(MYID), 2'd2};
        step();
        rd_sel = 1'b0;
        chk("R12 first commit", 32'(rd_data), 32'hB0);
        step();
        chk("R12 second commit", 32'(rd_data), 32'hA1);

        sel(2, 3);
        step();
        chk("R9 oe off on mismatch", 32'(out_invalid_oe), 0);
        rd(); rd();
        sel(MYID, 3);
        step();
        chk("R9 oe back on", 32'(out_invalid_oe), 1);
        chk("R11 deselected reads ignored", 32'(rd_data), 32'hB0);
        chk("R11 flag valid", 32'(out_invalid), 0);
        chk("R9 bus driven low", 32'(out_invalid_bus), 0);

        repeat (3) step();
        wr(0, 8'h77);
        step();
        chk("R10 data hold", 32'(rd_data), 32'hB0);
        chk("R10 flag hold", 32'(out_invalid), 0);
        sel(MYID, 0);
        step();
        chk("R2 late write shown", 32'(rd_data), 32'h77);

        finish_run();
    end
endmodule